// File: doc/BRIEF.md
# Context-Switched 16-bit Arithmetic and Logic Unit

This block is the arithmetic cell of a coarse-grained reconfigurable array. It takes two 16-bit operands and applies one of thirteen operations: signed multiply, add, subtract, a configurable shift, six two-input bitwise functions, invert, and signed maximum and minimum. It returns a registered result together with overflow, error and comparison flags.

The operation is not driven directly. Four configuration words are kept inside the block, and a 2-bit select input picks one of them on every cycle. The function can therefore change from one cycle to the next with no reload. Each word is written through a small port that carries a context index and the word.

A configuration word is 11 bits wide. Bits [3:0] hold the opcode. Bit [4] is the shift direction, with 0 meaning left and 1 meaning right. Bits [6:5] hold the shift kind: 00 logical, 01 arithmetic, 10 rotate, and 11 behaves as logical. Bits [10:7] hold the shift amount. The opcode values are MUL=0, ADD=1, SUB=2, SHIFT=3, AND=4, NAND=5, OR=6, NOR=7, XOR=8, XNOR=9, NOT=10, MAX=11 and MIN=12.

Top module: `ctx_alu`

## Requirements
- R1: Reset clears the result, all flags and the valid output. It also sets all four context words to zero, which selects MUL.
- R2: On each cycle, ctxSel picks the context word that governs the operation. A word written through cfgWe/cfgIdx/cfgWord is first used on the cycle after the write. An operation issued in the same cycle as a write to its own context uses the old word.
- R3: ADD and SUB wrap modulo 2^16. resOvf is 1 exactly when the signed result overflows.
- R4: MUL forms the 32-bit signed product and returns bits [30:15]. When those bits cannot represent the product (only 0x8000 times 0x8000), the result saturates to 0x7FFF, or 0x8000 for a negative product, and resOvf is 1.
- R5: AND, NAND, OR, NOR, XOR and XNOR return the bitwise function of A and B.
- R6: NOT returns the inverse of A, and B has no effect on it.
- R7: SHIFT applies the configured direction, kind and amount (0 to 15) to A. An arithmetic left shift equals a logical left shift. A rotate moves no bits out of the word.
- R8: MAX and MIN compare A and B as signed values and return the larger or the smaller one. When A and B are equal, the result is A.
- R9: Opcodes 13 to 15 return zero with resErr at 1. Every defined opcode returns resErr at 0.
- R10: Results appear one cycle after an operation is issued with inValid high, and resValid marks them. A cycle with inValid low drops resValid and leaves resData unchanged.
- R11: resGt is 1 when A is greater than B as signed values. resEq is 1 when A equals B.
- R12: resOvf is 0 for every operation other than ADD, SUB and MUL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctxSel | input | 2 | Context used by the operation this cycle |
| cfgWe | input | 1 | Configuration write strobe |
| cfgIdx | input | 2 | Context written |
| cfgWord | input | 11 | Configuration word |
| inValid | input | 1 | Operands valid, issue an operation |
| opA | input | 16 | Operand A |
| opB | input | 16 | Operand B |
| resData | output | 16 | Registered result |
| resValid | output | 1 | Result valid |
| resOvf | output | 1 | Overflow or saturation |
| resErr | output | 1 | Undefined opcode |
| resGt | output | 1 | A greater than B, signed |
| resEq | output | 1 | A equal to B |

## Verification
The bench sweeps every opcode across a grid of signed corner operands and every shift direction, kind and amount. It goes after 0x8000 squared, where a multiplier missing its saturation would return 0x8000, a negative number, as the result. It covers equal operands in MAX and MIN, where a wrong tie rule would return B. It covers mixed-sign comparisons, which an unsigned comparator gets backwards. It also covers writing the selected context in the same cycle it is used, where a storage read placed after the write would change the operation already in flight.

// File: rtl/ctx_alu_pkg.sv
package ctx_alu_pkg;

  localparam int OP_W    = 4;
  localparam int SHAMT_W = 4;
  localparam int CFG_W   = OP_W + 1 + 2 + SHAMT_W;

  typedef enum logic [OP_W-1:0] {
    OP_MUL  = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SHF  = 4'd3,
    OP_AND  = 4'd4,
    OP_NAND = 4'd5,
    OP_OR   = 4'd6,
    OP_NOR  = 4'd7,
    OP_XOR  = 4'd8,
    OP_XNOR = 4'd9,
    OP_NOT  = 4'd10,
    OP_MAX  = 4'd11,
    OP_MIN  = 4'd12
  } opcode_e;

  localparam logic [OP_W-1:0] LAST_OP = 4'd12;

  typedef enum logic [1:0] {
    SH_LOGIC = 2'd0,
    SH_ARITH = 2'd1,
    SH_ROT   = 2'd2,
    SH_ALT   = 2'd3
  } shkind_e;

  // Packed from MSB: amount, kind, direction, opcode
  typedef struct packed {
    logic [SHAMT_W-1:0] shAmt;
    shkind_e            shKind;
    logic               shRight;
    logic [OP_W-1:0]    op;
  } ctx_word_t;

  typedef struct packed {
    logic               load;
    logic               badOp;
    opcode_e            op;
    logic               shRight;
    shkind_e            shKind;
    logic [SHAMT_W-1:0] shAmt;
  } alu_strobe_t;

endpackage

// File: rtl/ctx_alu_ctrl.sv
module ctx_alu_ctrl
  import ctx_alu_pkg::*;
#(
  parameter int NUM_CTX = 4,
  localparam int IDX_W = $clog2(NUM_CTX)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] ctxSel,
  input  logic             cfgWe,
  input  logic [IDX_W-1:0] cfgIdx,
  input  ctx_word_t        cfgWord,
  input  logic             inValid,
  output alu_strobe_t      strb
);

  ctx_word_t ctxMem [NUM_CTX];
  ctx_word_t liveWord;

  // Context storage: written at the edge, read combinationally before it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CTX; i++) ctxMem[i] <= '0;
    end else if (cfgWe) begin
      ctxMem[cfgIdx] <= cfgWord;
    end
  end

  assign liveWord = ctxMem[ctxSel];

  always_comb begin
    strb.load    = inValid;
    strb.badOp   = (liveWord.op > LAST_OP);
    strb.op      = opcode_e'(liveWord.op);
    strb.shRight = liveWord.shRight;
    strb.shKind  = liveWord.shKind;
    strb.shAmt   = liveWord.shAmt;
  end

  // R2: a written word is held in storage on the following cycle
  a_r2_ctx_write: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && !(cfgIdx == ctxSel)) |=> (ctxMem[$past(cfgIdx)] == $past(cfgWord)));

  // R9: the undefined-opcode strobe is raised only for codes above the last one
  a_r9_bad_decode: assert property (@(posedge clk) disable iff (!rstN)
    strb.badOp |-> (liveWord.op >= 4'd13));

endmodule

// File: rtl/ctx_alu_dp.sv
module ctx_alu_dp
  import ctx_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int PW    = 2 * DATA_W,
  localparam int MSB   = DATA_W - 1,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  alu_strobe_t       strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] resData,
  output logic              resValid,
  output logic              resOvf,
  output logic              resErr,
  output logic              resGt,
  output logic              resEq
);

  localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_MAX = {1'b1, {(DATA_W-1){1'b0}}};

  // Multiplier with Q-format slice and saturation
  logic signed [PW-1:0] aExt, bExt, prod;
  logic [DATA_W-1:0]    mulRes;
  logic                 mulOvf;

  assign aExt = {{DATA_W{opA[MSB]}}, opA};
  assign bExt = {{DATA_W{opB[MSB]}}, opB};
  assign prod = aExt * bExt;

  always_comb begin
    mulOvf = (prod[PW-1] != prod[PW-2]);
    if (mulOvf) mulRes = prod[PW-1] ? NEG_MAX : POS_MAX;
    else        mulRes = prod[PW-2 -: DATA_W];
  end

  // Adder and subtractor with signed overflow detection
  logic [DATA_W-1:0] sumRes, difRes;
  logic              sumOvf, difOvf;

  assign sumRes = opA + opB;
  assign difRes = opA - opB;
  assign sumOvf = (opA[MSB] == opB[MSB]) && (sumRes[MSB] != opA[MSB]);
  assign difOvf = (opA[MSB] != opB[MSB]) && (difRes[MSB] != opA[MSB]);

  // Shifter: logical, arithmetic and rotate in both directions
  logic [SH_W-1:0]   shAmt;
  logic [PW-1:0]     dbl, rotLw, rotRw;
  logic [DATA_W-1:0] shRes;

  assign shAmt = SH_W'(strb.shAmt);
  assign dbl   = {opA, opA};
  assign rotLw = dbl << shAmt;
  assign rotRw = dbl >> shAmt;

  always_comb begin
    unique case (strb.shKind)
      SH_ARITH: shRes = strb.shRight ? DATA_W'($unsigned($signed(opA) >>> shAmt))
                                     : opA << shAmt;
      SH_ROT:   shRes = strb.shRight ? rotRw[DATA_W-1:0] : rotLw[PW-1 -: DATA_W];
      default:  shRes = strb.shRight ? opA >> shAmt : opA << shAmt;
    endcase
  end

  // Signed comparison shared by MAX, MIN and the flags
  logic aGtB, aLtB, aEqB;
  assign aGtB = $signed(opA) > $signed(opB);
  assign aLtB = $signed(opA) < $signed(opB);
  assign aEqB = (opA == opB);

  // Result selection
  logic [DATA_W-1:0] nextData;
  logic              nextOvf;

  always_comb begin
    nextData = '0;
    nextOvf  = 1'b0;
    if (!strb.badOp) begin
      unique case (strb.op)
        OP_MUL:  begin nextData = mulRes; nextOvf = mulOvf; end
        OP_ADD:  begin nextData = sumRes; nextOvf = sumOvf; end
        OP_SUB:  begin nextData = difRes; nextOvf = difOvf; end
        OP_SHF:  nextData = shRes;
        OP_AND:  nextData = opA & opB;
        OP_NAND: nextData = ~(opA & opB);
        OP_OR:   nextData = opA | opB;
        OP_NOR:  nextData = ~(opA | opB);
        OP_XOR:  nextData = opA ^ opB;
        OP_XNOR: nextData = ~(opA ^ opB);
        OP_NOT:  nextData = ~opA;
        OP_MAX:  nextData = aLtB ? opB : opA;
        OP_MIN:  nextData = aGtB ? opB : opA;
        default: nextData = '0;
      endcase
    end
  end

  // Output register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resData  <= '0;
      resValid <= 1'b0;
      resOvf   <= 1'b0;
      resErr   <= 1'b0;
      resGt    <= 1'b0;
      resEq    <= 1'b0;
    end else begin
      resValid <= strb.load;
      if (strb.load) begin
        resData <= nextData;
        resOvf  <= nextOvf;
        resErr  <= strb.badOp;
        resGt   <= aGtB;
        resEq   <= aEqB;
      end
    end
  end

  // R10: valid tracks the issue strobe with one cycle of latency
  a_r10_valid_rise: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> resValid);
  a_r10_valid_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> (!resValid && $stable(resData)));

  // R4: the one product that escapes the slice saturates positive
  a_r4_mul_sat: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.badOp && strb.op == OP_MUL && opA == NEG_MAX && opB == NEG_MAX)
      |=> (resData == POS_MAX && resOvf));

  // R8: maximum is not below either operand
  a_r8_max_bound: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.badOp && strb.op == OP_MAX)
      |=> ($signed(resData) >= $signed($past(opA)) && $signed(resData) >= $signed($past(opB))));

  // R9: undefined opcodes give a zero result
  a_r9_err_zero: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resErr) |-> (resData == '0 && !resOvf));

  // R11: equal and greater are exclusive
  a_r11_flags: assert property (@(posedge clk) disable iff (!rstN)
    !(resGt && resEq));

  // R12: only arithmetic opcodes may flag overflow
  a_r12_ovf_scope: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && (strb.badOp || !(strb.op inside {OP_MUL, OP_ADD, OP_SUB}))) |=> !resOvf);

endmodule

// File: rtl/ctx_alu.sv
module ctx_alu
  import ctx_alu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NUM_CTX = 4,
  localparam int IDX_W  = $clog2(NUM_CTX)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  ctxSel,
  input  logic              cfgWe,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] resData,
  output logic              resValid,
  output logic              resOvf,
  output logic              resErr,
  output logic              resGt,
  output logic              resEq
);

  alu_strobe_t strb;

  ctx_alu_ctrl #(.NUM_CTX(NUM_CTX)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .ctxSel  (ctxSel),
    .cfgWe   (cfgWe),
    .cfgIdx  (cfgIdx),
    .cfgWord (ctx_word_t'(cfgWord)),
    .inValid (inValid),
    .strb    (strb)
  );

  ctx_alu_dp #(.DATA_W(DATA_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .opA      (opA),
    .opB      (opB),
    .resData  (resData),
    .resValid (resValid),
    .resOvf   (resOvf),
    .resErr   (resErr),
    .resGt    (resGt),
    .resEq    (resEq)
  );

endmodule

// File: tb/tb_ctx_alu.sv
`timescale 1ns/1ps
module tb_ctx_alu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  ctxSel = '0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgIdx = '0;
  logic [10:0] cfgWord = '0;
  logic        inValid = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic [15:0] resData;
  logic        resValid, resOvf, resErr, resGt, resEq;

  int errs = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  ctx_alu dut (
    .clk(clk), .rstN(rstN), .ctxSel(ctxSel), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .cfgWord(cfgWord), .inValid(inValid), .opA(opA), .opB(opB),
    .resData(resData), .resValid(resValid), .resOvf(resOvf), .resErr(resErr),
    .resGt(resGt), .resEq(resEq)
  );

  localparam logic [15:0] VALS [12] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
    16'h8000, 16'h4000, 16'hC000, 16'h1234, 16'hA5A5, 16'h0002, 16'hFFFE, 16'h0100};

  function automatic logic [10:0] mkCfg(input int op, input int dir, input int kind, input int amt);
    return {4'(amt), 2'(kind), 1'(dir), 4'(op)};
  endfunction

  // Expected {err, ovf, data} from the requirements
  function automatic logic [17:0] model(input logic [10:0] c, input logic [15:0] a, input logic [15:0] b);
    int op, amt, sa, sb, p, r;
    logic [15:0] d;
    logic ov;
    op = int'(c[3:0]); amt = int'(c[10:7]);
    sa = int'($signed(a)); sb = int'($signed(b));
    d = '0; ov = 1'b0;
    case (op)
      0: begin
        p = sa * sb; r = p / 32768;
        if (p < 0 && (p % 32768) != 0) r = r - 1;
        if (r > 32767) begin d = 16'h7FFF; ov = 1'b1; end
        else if (r < -32768) begin d = 16'h8000; ov = 1'b1; end
        else d = 16'(r);
      end
      1: begin r = sa + sb; d = 16'(r); ov = (r > 32767) || (r < -32768); end
      2: begin r = sa - sb; d = 16'(r); ov = (r > 32767) || (r < -32768); end
      3: begin
        if (c[6:5] == 2'd2) begin
          for (int i = 0; i < 16; i++)
            d[i] = c[4] ? a[(i + amt) % 16] : a[(i - amt + 16) % 16];
        end else if (c[4] == 1'b0) begin
          d = a << amt;
        end else if (c[6:5] == 2'd1) begin
          d = 16'(sa >>> amt);
        end else begin
          d = a >> amt;
        end
      end
      4: d = a & b;
      5: d = ~(a & b);
      6: d = a | b;
      7: d = ~(a | b);
      8: d = a ^ b;
      9: d = ~(a ^ b);
      10: d = ~a;
      11: d = (sb > sa) ? b : a;
      12: d = (sb < sa) ? b : a;
      default: return {1'b1, 1'b0, 16'h0000};
    endcase
    return {1'b0, ov, d};
  endfunction

  function automatic string reqOf(input int op);
    case (op)
      0: return "R4";
      1, 2: return "R3";
      3: return "R7";
      4, 5, 6, 7, 8, 9: return "R5";
      10: return "R6";
      11, 12: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic writeCfg(input int idx, input logic [10:0] w);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = 2'(idx); cfgWord = w; inValid = 1'b0;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // Issue one operation and check all outputs 1 ns after the capturing edge
  task automatic issue(input int ctx, input logic [10:0] w, input logic [15:0] a, input logic [15:0] b, input string req);
    logic [17:0] e;
    e = model(w, a, b);
    ctxSel = 2'(ctx); opA = a; opB = b; inValid = 1'b1;
    @(posedge clk); #1;
    chk(req, "data", 32'(resData), 32'(e[15:0]));
    chk(req, "ovf", 32'(resOvf), 32'(e[16]));
    chk("R9", "err", 32'(resErr), 32'(e[17]));
    chk("R10", "valid", 32'(resValid), 32'd1);
    chk("R11", "gt", 32'(resGt), 32'($signed(a) > $signed(b)));
    chk("R11", "eq", 32'(resEq), 32'(a == b));
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "data", 32'(resData), 32'd0);
    chk("R1", "valid", 32'(resValid), 32'd0);
    chk("R1", "ovf", 32'(resOvf), 32'(0));
    @(negedge clk);
    rstN = 1'b1;
    // R1: every context defaults to MUL
    for (int c = 0; c < 4; c++) issue(c, 11'd0, 16'h4000, 16'h4000, "R1");

    // Sweep all non-shift opcodes across the operand grid (R3 R4 R5 R6 R8 R12)
    for (int op = 0; op < 16; op++) begin
      if (op == 3) continue;
      writeCfg(op % 4, mkCfg(op, 0, 0, 0));
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          issue(op % 4, mkCfg(op, 0, 0, 0), VALS[i], VALS[j], reqOf(op));
    end

    // R7: every direction, kind and amount
    for (int dir = 0; dir < 2; dir++)
      for (int kind = 0; kind < 4; kind++)
        for (int amt = 0; amt < 16; amt++) begin
          writeCfg(1, mkCfg(3, dir, kind, amt));
          issue(1, mkCfg(3, dir, kind, amt), 16'h8421, 16'h0000, "R7");
          issue(1, mkCfg(3, dir, kind, amt), 16'hF00D, 16'h1234, "R7");
        end

    // R10: idle cycle drops valid and keeps data
    issue(0, mkCfg(12, 0, 0, 0), 16'h0005, 16'h0009, "R10");
    held = resData;
    @(negedge clk);
    opA = 16'h7777; opB = 16'h1111; inValid = 1'b0;
    @(posedge clk); #1;
    chk("R10", "idle valid", 32'(resValid), 32'd0);
    chk("R10", "idle data", 32'(resData), 32'(held));

    // R2: per-cycle context switching
    writeCfg(0, mkCfg(1, 0, 0, 0));
    writeCfg(1, mkCfg(2, 0, 0, 0));
    writeCfg(2, mkCfg(8, 0, 0, 0));
    writeCfg(3, mkCfg(11, 0, 0, 0));
    for (int k = 0; k < 8; k++) begin
      logic [10:0] w;
      case (k % 4)
        0: w = mkCfg(1, 0, 0, 0);
        1: w = mkCfg(2, 0, 0, 0);
        2: w = mkCfg(8, 0, 0, 0);
        default: w = mkCfg(11, 0, 0, 0);
      endcase
      issue(k % 4, w, 16'h0300, 16'h0120, "R2");
    end

    // R2: write to the selected context in the same cycle as its use
    @(negedge clk);
    ctxSel = 2'd0; opA = 16'h0010; opB = 16'h0003; inValid = 1'b1;
    cfgWe = 1'b1; cfgIdx = 2'd0; cfgWord = mkCfg(2, 0, 0, 0);
    @(posedge clk); #1;
    chk("R2", "inflight old ctx", 32'(resData), 32'h0013);
    @(negedge clk);
    cfgWe = 1'b0;
    @(posedge clk); #1;
    chk("R2", "new ctx next cycle", 32'(resData), 32'h000D);
    @(negedge clk);
    inValid = 1'b0;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule